// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block decides whether store-exclusive operations pass. It watches one access port that all processors share. Per cycle the port carries at most one operation: a load-exclusive, a store-exclusive, a clear-exclusive or a plain store. Each operation comes with an address, a size code, a processor ID, a shareable flag and a device-memory flag.

For every processor the block keeps a private reservation, called the local slot. For shareable traffic it also keeps a tagged reservation per processor, called the global slot. Writes from other bus masters arrive on a snoop port, and they cancel any global tag they overlap. Writes from other processors on the access port cancel overlapping global tags in the same way.

One cycle after each operation, the block gives a pass/fail status for store-exclusives and a write-enable for the memory behind it. An address window reserved for system control is treated specially: exclusives there never touch the reservation state and always succeed.

Each local slot is a two-state machine:
- States: `LM_OPEN` and `LM_EXCL`.
- Transitions:
  - *arm*: a load-exclusive outside the system window moves the slot to `LM_EXCL`.
  - *disarm*: a clear-exclusive, a store-exclusive outside the window, or an exception pulse moves it back to `LM_OPEN`. *disarm* wins over *arm*.

Each global slot is also a two-state machine:
- States: `GM_IDLE` and `GM_TAGGED`.
- Transitions:
  - *tag*: a shareable load-exclusive with a global monitor present moves the slot to `GM_TAGGED`.
  - *kill*: an overlapping write from another master or processor moves it back to `GM_IDLE`. *tag* wins over *kill*.

Top module: `excl_monitor`

## Requirements
- R1: The operation code `acc_op` uses these values: 1 for load-exclusive, 2 for store-exclusive, 3 for clear-exclusive, 4 for plain store, and 0 for idle. A load-exclusive arms the local slot of its processor with its address and size. A following non-shareable store-exclusive with the same address and size then passes.
- R2: A clear-exclusive returns the processor's local slot to open, so a later store-exclusive fails.
- R3: A store-exclusive outside the system window always leaves the local slot open, whether it passes or fails. A second store-exclusive therefore fails.
- R4: A pulse on `exc_clr[p]` opens processor p's local slot and leaves the slots of other processors unchanged.
- R5: A plain store from the same processor does not disarm its local slot.
- R6: For a shareable access, a store-exclusive passes only if the local slot matches and the global tag for that processor also matches.
- R7: An access with `acc_device`=1 is handled as shareable whatever `acc_shareable` says.
- R8: Exclusives with addresses inside SYS_LO..SYS_HI (default 0xE0000000..0xE00FFFFF) leave all slots unchanged. A store-exclusive there always gives status 0 and asserts the write-enable.
- R9: When the access is shareable and `glob_present`=0, every store-exclusive fails.
- R10: The outputs are registered and appear in the cycle after the operation. `stex_status` is 0 for a pass and 1 for a fail. `mem_we` is 0 whenever `stex_status` is 1, and 1 after a plain store or a passing store-exclusive.
- R11: A snoop write whose ID differs from processor p, or an access-port write from another processor, clears p's global tag when its byte range overlaps that tag. Non-overlapping writes, and snoops carrying p's own ID, do not clear it.
- R12: A store-exclusive whose address or size code differs from the reservation fails, and it still opens the local slot.
- R13: The reservation state of each processor is independent of operations issued by other processors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Operation present this cycle |
| acc_op | input | 3 | Operation code (see R1) |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_size | input | 2 | Size code; access spans 2^size bytes |
| acc_pid | input | PID_W | Issuing processor |
| acc_shareable | input | 1 | Shareable attribute |
| acc_device | input | 1 | Device-memory attribute |
| glob_present | input | 1 | Target region has a global monitor |
| exc_clr | input | NUM_PROC | Exception entry/return pulse per processor |
| snoop_valid | input | 1 | External write observed |
| snoop_id | input | ID_W | Master ID of the external write |
| snoop_addr | input | ADDR_W | Byte address of the external write |
| snoop_size | input | 2 | Size code of the external write |
| stex_status | output | 1 | Store-exclusive result, 1 = fail |
| mem_we | output | 1 | Memory write-enable |

## Verification
The assertions check these properties on every cycle:
- A failed status never coincides with a write.
- Every store-exclusive, clear-exclusive or exception pulse leaves the affected local slot open in the next cycle.
- The system window always passes.
- A shareable store-exclusive without a global monitor always fails.

Some behaviour depends on history that a single-cycle property cannot capture. This covers address and size matching against the stored reservation, byte-range overlap in the snoop and cross-processor cancellation, the independence of processors, and a plain store leaving a reservation intact. The bench covers these with sweeps over attributes, sizes and offsets.

// File: rtl/exm_pkg.sv
package exm_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_LDEX  = 3'd1,
        OP_STEX  = 3'd2,
        OP_CLREX = 3'd3,
        OP_STORE = 3'd4
    } exm_op_e;

    typedef enum logic {
        LM_OPEN = 1'b0,
        LM_EXCL = 1'b1
    } lm_state_e;

    typedef enum logic {
        GM_IDLE   = 1'b0,
        GM_TAGGED = 1'b1
    } gm_state_e;

endpackage

// File: rtl/exm_local_slot.sv
module exm_local_slot
    import exm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              disarm_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output logic              match_o,
    output logic              excl_o
);
    lm_state_e         state_q, state_d;
    logic [ADDR_W-1:0] tag_addr_q;
    logic [1:0]        tag_size_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LM_OPEN: if (!disarm_i && arm_i) state_d = LM_EXCL;
            LM_EXCL: if (disarm_i)           state_d = LM_OPEN;
            default:                         state_d = LM_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= LM_OPEN;
            tag_addr_q <= '0;
            tag_size_q <= '0;
        end else begin
            state_q <= state_d;
            if (arm_i && !disarm_i) begin
                tag_addr_q <= addr_i;
                tag_size_q <= size_i;
            end
        end
    end

    assign excl_o  = (state_q == LM_EXCL);
    assign match_o = excl_o && (tag_addr_q == addr_i) && (tag_size_q == size_i);
endmodule

// File: rtl/exm_global_slot.sv
module exm_global_slot
    import exm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tag_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              wa_v_i,
    input  logic [ADDR_W-1:0] wa_addr_i,
    input  logic [1:0]        wa_size_i,
    input  logic              sn_v_i,
    input  logic [ADDR_W-1:0] sn_addr_i,
    input  logic [1:0]        sn_size_i,
    output logic              match_o
);
    localparam int XW = ADDR_W + 1;

    gm_state_e         state_q, state_d;
    logic [ADDR_W-1:0] tag_addr_q;
    logic [1:0]        tag_size_q;
    logic              kill;

    function automatic logic ranges_meet(input logic [ADDR_W-1:0] a, input logic [1:0] sa,
                                         input logic [ADDR_W-1:0] b, input logic [1:0] sb);
        logic [XW-1:0] alo, ahi, blo, bhi;
        alo = {1'b0, a};
        blo = {1'b0, b};
        ahi = alo + (XW'(1) << sa) - XW'(1);
        bhi = blo + (XW'(1) << sb) - XW'(1);
        return (alo <= bhi) && (blo <= ahi);
    endfunction

    assign kill = (wa_v_i && ranges_meet(wa_addr_i, wa_size_i, tag_addr_q, tag_size_q)) ||
                  (sn_v_i && ranges_meet(sn_addr_i, sn_size_i, tag_addr_q, tag_size_q));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GM_IDLE:   if (tag_i)          state_d = GM_TAGGED;
            GM_TAGGED: if (!tag_i && kill) state_d = GM_IDLE;
            default:                       state_d = GM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= GM_IDLE;
            tag_addr_q <= '0;
            tag_size_q <= '0;
        end else begin
            state_q <= state_d;
            if (tag_i) begin
                tag_addr_q <= addr_i;
                tag_size_q <= size_i;
            end
        end
    end

    assign match_o = (state_q == GM_TAGGED) && (tag_addr_q == addr_i) && (tag_size_q == size_i);
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import exm_pkg::*;
#(
    parameter int NUM_PROC = 2,
    parameter int PID_W    = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
    parameter int ID_W     = 2,
    parameter int ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] SYS_LO = 32'hE000_0000,
    parameter logic [ADDR_W-1:0] SYS_HI = 32'hE00F_FFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic [2:0]          acc_op,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [1:0]          acc_size,
    input  logic [PID_W-1:0]    acc_pid,
    input  logic                acc_shareable,
    input  logic                acc_device,
    input  logic                glob_present,
    input  logic [NUM_PROC-1:0] exc_clr,
    input  logic                snoop_valid,
    input  logic [ID_W-1:0]     snoop_id,
    input  logic [ADDR_W-1:0]   snoop_addr,
    input  logic [1:0]          snoop_size,
    output logic                stex_status,
    output logic                mem_we
);
    logic op_ldex, op_stex, op_clrex, op_store;
    logic in_sys, shr, loc_ok, glb_ok, stex_pass, we_now;
    logic [NUM_PROC-1:0] lm_match, lm_excl, gm_match;

    assign op_ldex  = acc_valid && (acc_op == OP_LDEX);
    assign op_stex  = acc_valid && (acc_op == OP_STEX);
    assign op_clrex = acc_valid && (acc_op == OP_CLREX);
    assign op_store = acc_valid && (acc_op == OP_STORE);
    assign in_sys   = (acc_addr >= SYS_LO) && (acc_addr <= SYS_HI);
    assign shr      = acc_shareable || acc_device;

    for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
        logic mine;
        assign mine = (acc_pid == PID_W'(p));

        exm_local_slot #(.ADDR_W(ADDR_W)) u_local (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm_i    (op_ldex && mine && !in_sys),
            .disarm_i (exc_clr[p] || (mine && (op_clrex || (op_stex && !in_sys)))),
            .addr_i   (acc_addr),
            .size_i   (acc_size),
            .match_o  (lm_match[p]),
            .excl_o   (lm_excl[p])
        );

        exm_global_slot #(.ADDR_W(ADDR_W)) u_global (
            .clk       (clk),
            .rst_n     (rst_n),
            .tag_i     (op_ldex && mine && !in_sys && shr && glob_present),
            .addr_i    (acc_addr),
            .size_i    (acc_size),
            .wa_v_i    (we_now && !mine),
            .wa_addr_i (acc_addr),
            .wa_size_i (acc_size),
            .sn_v_i    (snoop_valid && (snoop_id != ID_W'(p))),
            .sn_addr_i (snoop_addr),
            .sn_size_i (snoop_size),
            .match_o   (gm_match[p])
        );
    end

    assign loc_ok    = lm_match[acc_pid];
    assign glb_ok    = gm_match[acc_pid];
    assign stex_pass = in_sys || (loc_ok && (!shr || (glob_present && glb_ok)));
    assign we_now    = op_store || (op_stex && stex_pass);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stex_status <= 1'b0;
            mem_we      <= 1'b0;
        end else begin
            stex_status <= op_stex && !stex_pass;
            mem_we      <= we_now;
        end
    end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
    parameter int NUM_PROC = 2,
    parameter int PID_W    = 1,
    parameter int ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] SYS_LO = 32'hE000_0000,
    parameter logic [ADDR_W-1:0] SYS_HI = 32'hE00F_FFFF
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_valid,
    input logic [2:0]          acc_op,
    input logic [ADDR_W-1:0]   acc_addr,
    input logic [PID_W-1:0]    acc_pid,
    input logic                acc_shareable,
    input logic                acc_device,
    input logic                glob_present,
    input logic [NUM_PROC-1:0] exc_clr,
    input logic [NUM_PROC-1:0] lm_excl,
    input logic                stex_status,
    input logic                mem_we
);
    logic sys_a, is_stex, is_clrex;
    assign sys_a    = (acc_addr >= SYS_LO) && (acc_addr <= SYS_HI);
    assign is_stex  = acc_valid && (acc_op == 3'd2);
    assign is_clrex = acc_valid && (acc_op == 3'd3);

    // R10
    fail_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stex_status |-> !mem_we);

    // R8
    sys_window_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_stex && sys_a) |=> (!stex_status && mem_we));

    // R9
    no_global_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_stex && !sys_a && (acc_shareable || acc_device) && !glob_present) |=> stex_status);

    for (genvar p = 0; p < NUM_PROC; p++) begin : g_p
        // R3
        stex_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_stex && !sys_a && acc_pid == PID_W'(p)) |=> !lm_excl[p]);
        // R4
        exc_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
            exc_clr[p] |=> !lm_excl[p]);
        // R2
        clrex_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_clrex && acc_pid == PID_W'(p)) |=> !lm_excl[p]);
    end
endmodule

bind excl_monitor excl_monitor_chk #(
    .NUM_PROC(NUM_PROC), .PID_W(PID_W), .ADDR_W(ADDR_W), .SYS_LO(SYS_LO), .SYS_HI(SYS_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_op(acc_op), .acc_addr(acc_addr),
    .acc_pid(acc_pid), .acc_shareable(acc_shareable), .acc_device(acc_device),
    .glob_present(glob_present), .exc_clr(exc_clr), .lm_excl(lm_excl),
    .stex_status(stex_status), .mem_we(mem_we)
);

// File: tb/excl_monitor_bench.sv
module excl_monitor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_op = 3'd0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [0:0]  acc_pid = '0;
    logic        acc_shareable = 1'b0;
    logic        acc_device = 1'b0;
    logic        glob_present = 1'b1;
    logic [1:0]  exc_clr = '0;
    logic        snoop_valid = 1'b0;
    logic [1:0]  snoop_id = '0;
    logic [31:0] snoop_addr = '0;
    logic [1:0]  snoop_size = '0;
    logic        stex_status, mem_we;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    localparam logic [2:0] LDEX = 3'd1, STEX = 3'd2, CLREX = 3'd3, STORE = 3'd4;
    localparam logic [31:0] A = 32'h2000_0100, B = 32'h2000_0200, SYS = 32'hE000_ED10;

    always #10 clk = ~clk;

    excl_monitor u_excl_monitor (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_op(acc_op), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_pid(acc_pid), .acc_shareable(acc_shareable),
        .acc_device(acc_device), .glob_present(glob_present), .exc_clr(exc_clr),
        .snoop_valid(snoop_valid), .snoop_id(snoop_id), .snoop_addr(snoop_addr),
        .snoop_size(snoop_size), .stex_status(stex_status), .mem_we(mem_we)
    );

    task automatic op(input logic [2:0] k, input logic [31:0] a, input logic [1:0] s,
                      input int pid, input logic sh, input logic dev);
        acc_valid = 1'b1; acc_op = k; acc_addr = a; acc_size = s;
        acc_pid = pid[0:0]; acc_shareable = sh; acc_device = dev;
        @(negedge clk);
        acc_valid = 1'b0; acc_op = 3'd0;
    endtask

    task automatic exc(input logic [1:0] m);
        exc_clr = m;
        @(negedge clk);
        exc_clr = '0;
    endtask

    task automatic snoop(input logic [1:0] id, input logic [31:0] a, input logic [1:0] s);
        snoop_valid = 1'b1; snoop_id = id; snoop_addr = a; snoop_size = s;
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic chk(input logic exp_fail, input string tag);
        checks++;
        if (stex_status !== exp_fail || mem_we !== !exp_fail) begin
            fails++;
            $display("FAIL %s: status=%b we=%b expected status=%b we=%b",
                     tag, stex_status, mem_we, exp_fail, !exp_fail);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        checks++;
        if (stex_status !== 1'b0 || mem_we !== 1'b0) begin
            fails++;
            $display("FAIL R10 reset: status=%b we=%b expected 0 0", stex_status, mem_we);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R6 R7 R9 R3: attribute sweep
        for (int pid = 0; pid < 2; pid++)
            for (int sh = 0; sh < 2; sh++)
                for (int dev = 0; dev < 2; dev++)
                    for (int gp = 0; gp < 2; gp++) begin
                        glob_present = gp[0];
                        op(CLREX, A, 2, pid, sh[0], dev[0]);
                        op(LDEX, A, 2, pid, sh[0], dev[0]);
                        op(STEX, A, 2, pid, sh[0], dev[0]);
                        chk((sh[0] || dev[0]) && !gp[0], "R1/R6/R7/R9 sweep");
                        op(STEX, A, 2, pid, sh[0], dev[0]);
                        chk(1'b1, "R3 second stex");
                    end
        glob_present = 1'b1;

        // R2
        op(LDEX, A, 2, 0, 0, 0); op(CLREX, A, 2, 0, 0, 0); op(STEX, A, 2, 0, 0, 0);
        chk(1'b1, "R2 clrex");

        // R4 and R13
        op(LDEX, A, 2, 0, 0, 0); exc(2'b01); op(STEX, A, 2, 0, 0, 0);
        chk(1'b1, "R4 exception");
        op(LDEX, A, 2, 0, 0, 0); exc(2'b10); op(STEX, A, 2, 0, 0, 0);
        chk(1'b0, "R4/R13 other exception");

        // R5
        op(LDEX, A, 2, 0, 0, 0); op(STORE, A, 2, 0, 0, 0);
        chk(1'b0, "R5 plain store writes");
        op(STEX, A, 2, 0, 0, 0);
        chk(1'b0, "R5 reservation kept");

        // R12 size/offset sweep
        for (int s = 0; s < 4; s++)
            for (int off = 0; off < 2; off++) begin
                op(LDEX, A, 2, 1, 0, 0);
                op(STEX, A + 32'(off * 4), s[1:0], 1, 0, 0);
                chk(!(s == 2 && off == 0), "R12 mismatch");
                op(STEX, A, 2, 1, 0, 0);
                chk(1'b1, "R12 local cleared");
            end

        // R11 global kills
        op(LDEX, A, 2, 0, 1, 0); snoop(2'd2, A + 2, 0); op(STEX, A, 2, 0, 1, 0);
        chk(1'b1, "R11 overlapping snoop");
        op(LDEX, A, 2, 0, 1, 0); snoop(2'd2, A + 4, 2); op(STEX, A, 2, 0, 1, 0);
        chk(1'b0, "R11 disjoint snoop");
        op(LDEX, A, 2, 0, 1, 0); snoop(2'd0, A, 2); op(STEX, A, 2, 0, 1, 0);
        chk(1'b0, "R11 own-id snoop");
        op(LDEX, A, 2, 0, 1, 0); op(STORE, A + 3, 0, 1, 1, 0);
        chk(1'b0, "R11 other store writes");
        op(STEX, A, 2, 0, 1, 0);
        chk(1'b1, "R11 other processor store");

        // R8 system window
        op(CLREX, A, 2, 0, 0, 0); op(STEX, SYS, 2, 0, 1, 1);
        chk(1'b0, "R8 sys stex no reservation");
        op(LDEX, A, 2, 0, 0, 0); op(LDEX, SYS, 2, 0, 0, 0); op(STEX, A, 2, 0, 0, 0);
        chk(1'b0, "R8 sys ldex leaves slot");
        op(LDEX, A, 2, 0, 0, 0); op(STEX, SYS, 2, 0, 0, 0); op(STEX, A, 2, 0, 0, 0);
        chk(1'b0, "R8 sys stex leaves slot");

        // R13 independence
        op(LDEX, A, 2, 0, 0, 0); op(LDEX, B, 2, 1, 0, 0);
        op(STEX, B, 2, 1, 0, 0);
        chk(1'b0, "R13 p1");
        op(STEX, A, 2, 0, 0, 0);
        chk(1'b0, "R13 p0");

        finish_up();
    end
endmodule